// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block turns a fast peripheral clock into the bit timing of an I2C initiator. A prescaler divides the peripheral clock by one plus a small pre-divide field, giving an internal tick. A phase state machine counts these ticks to build each SCL period: it drives SCL low for the first half, releases it, waits until the line is really high (so a target that stretches the clock pauses the count), then counts out the high half. It gives the initiator engine one-cycle strobes at the start of the low phase, at the start of the high phase and at the sampling point in the middle of the high phase.

The divider word packs the pre-divide field in its low bits (two or three bits wide, chosen by the `CDF_W` parameter) and a 6-bit period field directly above it. A separate 8-bit compensation count, covering SCL fall time, rise time and internal delay in whole ticks, is added to the period. One period lasts 20 + 8 × period field + compensation ticks. New divider values are taken only at a period boundary. A second counter provides the first-bit setup delay between SDA and SCL, counted in internal ticks.

The phase machine has four states: IDLE (disabled, counters cleared, SCL released), LOW (SCL driven low, counting low ticks), WAIT (SCL released, waiting for a tick on which the line reads high) and HIGH (counting high ticks). Transitions: IDLE to LOW when enabled (divider values loaded); LOW to WAIT after the low count; WAIT to HIGH on a tick with SCL high; HIGH to LOW after the high count (divider values reloaded); any state to IDLE when the enable is low.

Top module: `i2c_scl_divider`

## Requirements
- R1: The internal tick `int_tick` is a one-cycle pulse every CDF+1 peripheral clock cycles, where CDF is the active pre-divide field; with CDF=0 it is high on every cycle of a running period.
- R2: The divider word is read as CDF = `div_cfg[CDF_W-1:0]` and period field SCGD = `div_cfg[CDF_W+5:CDF_W]` (6 bits, 0 to 63).
- R3: With no clock stretching, consecutive `scl_low_stb` pulses are (CDF+1) × P cycles apart, where P = 20 + 8 × SCGD + `comp_ticks`.
- R4: SCL is driven low for floor(P/2) ticks; `scl_high_stb` comes (CDF+1) × (floor(P/2) + 1) cycles after `scl_low_stb`.
- R5: `scl_samp_stb` comes (CDF+1) × (floor(P/2) + floor(H/2)) cycles after `scl_low_stb`, where H = P − floor(P/2).
- R6: After SCL is released, no `scl_high_stb` is issued while `scl_in` reads low; the first tick that sees `scl_in` high counts as the first high tick, and the next `scl_low_stb` follows (CDF+1) × (H − 1) cycles after `scl_high_stb`.
- R7: A change of `div_cfg` or `comp_ticks` during a period does not alter that period; it takes effect from the next `scl_low_stb`.
- R8: After a `first_go` pulse, `setup_done` pulses for one cycle, one cycle after the (`setup_sel` + 2)-th internal tick seen after the go cycle; encoding 4 gives 6 ticks (the usual setting) and 15 gives 17 ticks.
- R9: While `enable` is low all strobes, `int_tick` and `scl_drive_low` are low; raising `enable` gives `scl_low_stb` in the cycle after it is sampled.
- R10: `scl_drive_low` is high during the low phase, including the `scl_low_stb` cycle, and low whenever `scl_high_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the divider; low holds all counters cleared |
| div_cfg | input | CDF_W+6 | Divider word: period field above pre-divide field |
| comp_ticks | input | 8 | Fall/rise/delay compensation, in ticks |
| setup_sel | input | 4 | First-bit setup delay code (delay = code + 2 ticks) |
| first_go | input | 1 | Starts a first-bit setup delay |
| scl_in | input | 1 | Sensed SCL line level |
| int_tick | output | 1 | Internal tick pulse |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_low_stb | output | 1 | Start of SCL low phase (period boundary) |
| scl_high_stb | output | 1 | Start of SCL high phase |
| scl_samp_stb | output | 1 | Sampling point within the high phase |
| setup_done | output | 1 | End of first-bit setup delay |

## Verification
Every result is due a fixed number of cycles after the `scl_low_stb` that opens its period: the high strobe after (CDF+1)(floor(P/2)+1) cycles, the sample strobe after (CDF+1)(floor(P/2)+floor(H/2)) cycles and the next low strobe after (CDF+1)P cycles, while the setup pulse is due one cycle after the counted tick and the first low strobe one cycle after the enable is sampled. The bench drives inputs on the falling edge, timestamps each strobe on the falling edge with a rising-edge cycle counter, and compares the differences with these formulas over a sweep of all pre-divide values and several period and compensation values. Stretching is checked by holding the line low well past the due time and expecting the high strobe on the very next falling edge after release.

// File: rtl/i2c_scl_divider_pkg.sv
package i2c_scl_divider_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } ph_state_e;

    localparam int BASE_TICKS = 20;
    localparam int SCGD_STEP  = 8;

endpackage

// File: rtl/rdiv_prescale.sv
module rdiv_prescale #(
    parameter int CDF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CDF_W-1:0] cdf,
    output logic             tick
);
    logic [CDF_W-1:0] cnt;

    assign tick = run && (cnt == cdf);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || cdf == '0));

endmodule

// File: rtl/rdiv_first_setup.sv
module rdiv_first_setup #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             go,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);
    localparam logic [SEL_W:0] SETUP_ADD = 2;
    localparam logic [SEL_W:0] LAST_ONE  = 1;

    logic             busy;
    logic [SEL_W:0]   remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
            done   <= 1'b0;
        end else if (!enable) begin
            busy   <= 1'b0;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy   <= 1'b1;
                    remain <= {1'b0, sel} + SETUP_ADD;
                end
            end else if (tick) begin
                if (remain == LAST_ONE) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    remain <= remain - LAST_ONE;
                end
            end
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/rdiv_phase_fsm.sv
module rdiv_phase_fsm
    import i2c_scl_divider_pkg::*;
#(
    parameter int CDF_W  = 3,
    parameter int SCGD_W = 6,
    parameter int COMP_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    tick,
    input  logic                    scl_in,
    input  logic [CDF_W+SCGD_W-1:0] cfg_in,
    input  logic [COMP_W-1:0]       comp_in,
    output logic [CDF_W-1:0]        cdf_act,
    output logic                    running,
    output logic                    scl_low,
    output logic                    low_stb,
    output logic                    high_stb,
    output logic                    samp_stb
);
    localparam int CFG_W   = CDF_W + SCGD_W;
    localparam int PER_MAX = BASE_TICKS + SCGD_STEP * ((1 << SCGD_W) - 1) + (1 << COMP_W) - 1;
    localparam int PER_W   = $clog2(PER_MAX + 1);
    localparam logic [PER_W-1:0] ONE = 1;

    ph_state_e          state, state_nx;
    logic [PER_W-1:0]   cnt, cnt_nx;
    logic               load;
    logic [SCGD_W-1:0]  scgd_act;
    logic [COMP_W-1:0]  comp_act;
    logic [PER_W-1:0]   period, low_len, high_len, high_half;

    always_comb begin
        period    = PER_W'(BASE_TICKS) + (PER_W'(scgd_act) << 3) + PER_W'(comp_act);
        low_len   = period >> 1;
        high_len  = period - low_len;
        high_half = high_len >> 1;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        load     = 1'b0;
        unique case (state)
            PH_IDLE: begin
                if (enable) begin
                    state_nx = PH_LOW;
                    cnt_nx   = '0;
                    load     = 1'b1;
                end
            end
            PH_LOW: begin
                if (tick) begin
                    if (cnt == low_len - ONE) begin
                        state_nx = PH_WAIT;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + ONE;
                    end
                end
            end
            PH_WAIT: begin
                if (tick && scl_in) begin
                    state_nx = PH_HIGH;
                    cnt_nx   = ONE;
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    if (cnt == high_len - ONE) begin
                        state_nx = PH_LOW;
                        cnt_nx   = '0;
                        load     = 1'b1;
                    end else begin
                        cnt_nx = cnt + ONE;
                    end
                end
            end
        endcase
        if (!enable) begin
            state_nx = PH_IDLE;
            cnt_nx   = '0;
            load     = 1'b0;
        end
    end

    // state register and active divider values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= PH_IDLE;
            cnt      <= '0;
            cdf_act  <= '0;
            scgd_act <= '0;
            comp_act <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (load) begin
                cdf_act  <= cfg_in[CDF_W-1:0];
                scgd_act <= cfg_in[CFG_W-1:CDF_W];
                comp_act <= comp_in;
            end
        end
    end

    // output strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_stb  <= 1'b0;
            high_stb <= 1'b0;
            samp_stb <= 1'b0;
        end else begin
            low_stb  <= load;
            high_stb <= (state == PH_WAIT) && (state_nx == PH_HIGH);
            samp_stb <= enable && (state == PH_HIGH) && tick && (cnt == high_half - ONE);
        end
    end

    assign running = (state != PH_IDLE);
    assign scl_low = (state == PH_LOW);

    // R6
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_WAIT && !scl_in && enable) |=> (state == PH_WAIT && !high_stb));

    // R9
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!low_stb && !high_stb && !scl_low));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !low_stb |-> ($stable(scgd_act) && $stable(comp_act) && $stable(cdf_act)));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_stb, high_stb, samp_stb}));

    // R10
    high_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_stb |-> !scl_low);

endmodule

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider #(
    parameter int CDF_W  = 3,
    parameter int SCGD_W = 6,
    parameter int COMP_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic [CDF_W+SCGD_W-1:0] div_cfg,
    input  logic [COMP_W-1:0]       comp_ticks,
    input  logic [SEL_W-1:0]        setup_sel,
    input  logic                    first_go,
    input  logic                    scl_in,
    output logic                    int_tick,
    output logic                    scl_drive_low,
    output logic                    scl_low_stb,
    output logic                    scl_high_stb,
    output logic                    scl_samp_stb,
    output logic                    setup_done
);
    logic [CDF_W-1:0] cdf_act;
    logic             running;

    rdiv_prescale #(.CDF_W(CDF_W)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .cdf   (cdf_act),
        .tick  (int_tick)
    );

    rdiv_phase_fsm #(
        .CDF_W  (CDF_W),
        .SCGD_W (SCGD_W),
        .COMP_W (COMP_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .tick     (int_tick),
        .scl_in   (scl_in),
        .cfg_in   (div_cfg),
        .comp_in  (comp_ticks),
        .cdf_act  (cdf_act),
        .running  (running),
        .scl_low  (scl_drive_low),
        .low_stb  (scl_low_stb),
        .high_stb (scl_high_stb),
        .samp_stb (scl_samp_stb)
    );

    rdiv_first_setup #(.SEL_W(SEL_W)) u_setup (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .tick   (int_tick),
        .go     (first_go),
        .sel    (setup_sel),
        .done   (setup_done)
    );

endmodule

// File: tb/i2c_scl_divider_tb.sv
module i2c_scl_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [8:0] div_cfg = '0;
    logic [7:0] comp_ticks = '0;
    logic [3:0] setup_sel = '0;
    logic       first_go = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_in;
    logic       int_tick, scl_drive_low, scl_low_stb, scl_high_stb, scl_samp_stb, setup_done;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign scl_in = !scl_drive_low && !stretch;

    i2c_scl_divider u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_cfg(div_cfg),
        .comp_ticks(comp_ticks), .setup_sel(setup_sel), .first_go(first_go),
        .scl_in(scl_in), .int_tick(int_tick), .scl_drive_low(scl_drive_low),
        .scl_low_stb(scl_low_stb), .scl_high_stb(scl_high_stb),
        .scl_samp_stb(scl_samp_stb), .setup_done(setup_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // which: 0 low strobe, 1 high strobe, 2 sample strobe, 4 tick
    task automatic wait_evt(input int which, output int t);
        t = -1;
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk);
            if ((which == 0 && scl_low_stb) || (which == 1 && scl_high_stb) ||
                (which == 2 && scl_samp_stb) || (which == 4 && int_tick)) begin
                t = cyc;
                return;
            end
        end
    endtask

    task automatic start_cfg(input int cdf, input int scgd, input int comp, output int t0);
        @(negedge clk);
        enable = 1'b0;
        div_cfg = 9'((scgd << 3) | cdf);
        comp_ticks = 8'(comp);
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        t0 = cyc;
        chk("R9 low strobe after enable", int'(scl_low_stb), 1);
        chk("R10 drive low at low strobe", int'(scl_drive_low), 1);
    endtask

    task automatic run_cfg(input int cdf, input int scgd, input int comp);
        int t0, t1, t2, t3, ta, tb, d, p, lo, hi;
        d = cdf + 1;
        p = 20 + 8 * scgd + comp;
        lo = p / 2;
        hi = p - lo;
        start_cfg(cdf, scgd, comp, t0);
        wait_evt(4, ta);
        wait_evt(4, tb);
        chk("R1 tick spacing", tb - ta, d);
        wait_evt(1, t1);
        chk("R4 high strobe offset", t1 - t0, d * (lo + 1));
        chk("R10 released at high strobe", int'(scl_drive_low), 0);
        wait_evt(2, t2);
        chk("R5 sample offset", t2 - t0, d * (lo + hi / 2));
        wait_evt(0, t3);
        chk("R3 period", t3 - t0, d * p);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t0, t1, t2, cnt;
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R9 while disabled
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            seen = seen | int_tick | scl_drive_low | scl_low_stb | scl_high_stb |
                   scl_samp_stb | setup_done;
        end
        chk("R9 idle outputs after reset", int'(seen), 0);

        // sweep of every pre-divide value
        for (int c = 0; c < 8; c++)
            for (int s = 0; s < 3; s++)
                for (int k = 0; k < 2; k++)
                    run_cfg(c, s * 2, k * 3);
        // R2 field placement with the widest values
        run_cfg(0, 63, 255);
        run_cfg(7, 63, 255);
        start_cfg(3, 40, 1, t0);
        wait_evt(0, t1);
        chk("R2 period field above pre-divide", t1 - t0, 4 * (20 + 320 + 1));

        // R7 change mid-period
        start_cfg(1, 1, 0, t0);
        div_cfg = 9'((0 << 3) | 0);
        comp_ticks = 8'd2;
        wait_evt(0, t1);
        chk("R7 old period kept", t1 - t0, 2 * 28);
        wait_evt(0, t2);
        chk("R7 new period applied", t2 - t1, 22);

        // R6 clock stretch
        start_cfg(0, 0, 0, t0);
        stretch = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            seen = seen | scl_high_stb;
        end
        chk("R6 no high strobe while stretched", int'(seen), 0);
        chk("R6 line released during stretch", int'(scl_drive_low), 0);
        stretch = 1'b0;
        @(negedge clk);
        t1 = cyc;
        chk("R6 high strobe after release", int'(scl_high_stb), 1);
        wait_evt(0, t2);
        chk("R6 remainder of period", t2 - t1, 9);

        // R8 first-bit setup delay
        for (int j = 0; j < 3; j++) begin
            start_cfg(2, 0, 0, t0);
            setup_sel = (j == 0) ? 4'd4 : ((j == 1) ? 4'd15 : 4'd0);
            first_go = 1'b1;
            @(negedge clk);
            first_go = 1'b0;
            cnt = 0;
            if (int_tick) cnt++;
            t2 = -1;
            for (int i = 0; i < 200 && t2 < 0; i++) begin
                @(negedge clk);
                if (setup_done) t2 = cnt;
                else if (int_tick) cnt++;
            end
            chk("R8 setup delay ticks", t2, int'(setup_sel) + 2);
        end

        // R9 disable mid-run
        start_cfg(0, 0, 0, t0);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            seen = seen | scl_drive_low | scl_low_stb | scl_high_stb | scl_samp_stb | int_tick;
        end
        chk("R9 quiet after disable", int'(seen), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule